// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder with Automatic Flush

This block is a serial convolutional encoder. It takes one information bit per clock on a valid/ready handshake and turns each accepted bit into a two-bit code symbol. The symbol is presented one cycle later with a valid strobe. The encoder keeps two memory elements. The newer one, m1, holds the previous information bit and the older one, m2, holds the bit before that. Together they form a four-state trellis. The first code bit is V1 = u XOR m1 and the second is V2 = m1. After each step the memory shifts: m2 takes m1 and m1 takes u.

A frame carries a fixed, parameterised number of data bits. Once the last data bit of a frame has been accepted, the block appends two zero-valued tail bits on its own, so that the trellis always returns to state 00. While the tail bits are being emitted it holds its input ready signal low. The symbol from the second tail bit carries an end-of-frame marker. A start-of-frame strobe, sampled only while the block is ready, empties the memory and restarts the data-bit count. A frame that is in progress can therefore be abandoned and a new one started.

Top module: `conv_flush_encoder`

## Requirements
- R1: Each accepted input bit (in_valid and in_ready both high at a rising edge) produces exactly one output symbol, with out_valid high in the following cycle. No symbol appears in a cycle that neither an accepted bit nor a tail bit precedes.
- R2: For a data bit u the symbol is out_v1 = u XOR m1 and out_v2 = m1, where m1 is the previous bit of the same frame, or 0 for the first bit of a frame. After each step m2 takes m1 and m1 takes u.
- R3: With four data bits per frame, the data bits 1,1,0,1 followed by the automatic tail produce the symbols (v1 v2) 10, 01, 11, 10, 11, 00, in that order.
- R4: After the DATA_BITS-th data bit of a frame is accepted, the block emits two tail symbols on the next two cycles, encoded with u = 0, whatever the inputs are doing.
- R5: in_ready is low on exactly the two cycles in which tail bits are being encoded. Bits offered on in_valid in those cycles are not consumed and have no effect on any symbol.
- R6: out_eof is high together with out_valid on the second tail symbol of each frame, and low at all other times.
- R7: After out_eof the encoder is in state 00, so a data bit u that opens the next frame produces the symbol (u, 0).
- R8: A sof strobe sampled while in_ready is high clears both memory elements and the data-bit count. A bit accepted in the same cycle is encoded as the first bit of the new frame, and the frame ends after DATA_BITS bits counted from that bit.
- R9: A sof strobe raised while in_ready is low is ignored. The tail symbols and out_eof are unchanged by it.
- R10: In a cycle with in_valid low and no tail pending, the encoder state does not change and out_valid is low in the next cycle.
- R11: While rst is high and in the cycle after it is released, out_valid and out_eof are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe; effective only while in_ready is high |
| in_valid | input | 1 | An information bit is offered |
| in_bit | input | 1 | The offered information bit |
| in_ready | output | 1 | The block can accept a bit this cycle (low during the tail) |
| out_valid | output | 1 | A code symbol is present |
| out_v1 | output | 1 | First code bit of the symbol (u XOR m1) |
| out_v2 | output | 1 | Second code bit of the symbol (m1) |
| out_eof | output | 1 | Marks the final tail symbol of a frame |

## Verification
The bench sweeps every four-bit data pattern and inserts idle gaps at varying positions. A design that let an idle cycle shift the memory would corrupt the next V2. A design that counted idle cycles as bits would end the frame early. During every tail the bench offers junk bits and a sof strobe. A block that did not hold in_ready low, or that obeyed sof there, would produce tail symbols with u = 1 or place the end marker at the wrong point. A frame is also abandoned halfway by a new sof. If the block failed to clear m1 the first bit would come out as 01 instead of 10. If it failed to restart the count, out_eof would come early. The fixed reference sequence and the first symbol after each end marker show that the tail really drives the trellis back to 00.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    // Number of memory elements; the tail length equals this value.
    localparam int MEM_LEN = 2;

    typedef logic [MEM_LEN-1:0] mem_t;   // bit 0 = m1 (newest), bit 1 = m2

    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_FLUSH = 1'b1
    } phase_e;

    typedef struct packed {
        logic v1;
        logic v2;
    } sym_t;

    // Symbol for information bit u with memory m.
    function automatic sym_t encode_sym(input logic u, input mem_t m);
        sym_t s;
        s.v1 = u ^ m[0];
        s.v2 = m[0];
        return s;
    endfunction

endpackage

// File: rtl/cfe_framer.sv
module cfe_framer
    import cfe_pkg::*;
#(
    parameter int DATA_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic sof,
    output logic in_ready,
    output logic step,
    output logic use_input,
    output logic clear,
    output logic last_sym
);
    localparam int CNT_W = $clog2(DATA_BITS + 1);
    localparam int FL_W  = (MEM_LEN > 1) ? $clog2(MEM_LEN) : 1;

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  base_cnt;
    logic [FL_W-1:0]   fcnt_q;
    logic              accept;
    logic              flushing;
    logic              last_data;
    logic              last_flush;

    assign in_ready   = (phase_q == PH_DATA);
    assign flushing   = (phase_q == PH_FLUSH);
    assign accept     = in_valid & in_ready;
    assign clear      = sof & in_ready;
    assign step       = accept | flushing;
    assign use_input  = in_ready;
    assign last_flush = (fcnt_q == FL_W'(MEM_LEN - 1));
    assign last_sym   = flushing & last_flush;

    always_comb begin
        base_cnt  = clear ? '0 : cnt_q;
        last_data = (base_cnt == CNT_W'(DATA_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            fcnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_DATA: begin
                    if (accept) begin
                        if (last_data) begin
                            phase_q <= PH_FLUSH;
                            cnt_q   <= '0;
                            fcnt_q  <= '0;
                        end else begin
                            cnt_q <= base_cnt + CNT_W'(1);
                        end
                    end else begin
                        cnt_q <= base_cnt;
                    end
                end
                default: begin
                    if (last_flush) begin
                        phase_q <= PH_DATA;
                        fcnt_q  <= '0;
                    end else begin
                        fcnt_q <= fcnt_q + FL_W'(1);
                    end
                end
            endcase
        end
    end

    // R4: the tail lasts exactly two cycles (MEM_LEN is 2 in the package).
    assert_flush_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flushing) |=> flushing ##1 !flushing);

endmodule

// File: rtl/cfe_memory.sv
module cfe_memory
    import cfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clear,
    input  logic u,
    output mem_t mem_q,
    output mem_t mem_eff
);
    // Memory seen by the encoder this cycle: empty when a frame restarts.
    assign mem_eff = clear ? '0 : mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q[0] <= 1'b0;
        end else if (step) begin
            mem_q[0] <= u;
        end else if (clear) begin
            mem_q[0] <= 1'b0;
        end
    end

    for (genvar i = 1; i < MEM_LEN; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= 1'b0;
            end else if (step) begin
                mem_q[i] <= mem_eff[i-1];
            end else if (clear) begin
                mem_q[i] <= 1'b0;
            end
        end
    end

    // R10: with no step and no restart the memory holds.
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(mem_q));

endmodule

// File: rtl/cfe_symout.sv
module cfe_symout
    import cfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  sym_t sym,
    input  logic last,
    output logic out_valid,
    output logic out_v1,
    output logic out_v2,
    output logic out_eof
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_v1    <= 1'b0;
            out_v2    <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= step;
            out_eof   <= step & last;
            if (step) begin
                out_v1 <= sym.v1;
                out_v2 <= sym.v2;
            end
        end
    end

    // R6: the end marker sits on a symbol that follows another symbol.
    assert_eof_valid_R6: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (out_valid && $past(out_valid)));

endmodule

// File: rtl/conv_flush_encoder.sv
module conv_flush_encoder
    import cfe_pkg::*;
#(
    parameter int DATA_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_v1,
    output logic out_v2,
    output logic out_eof
);
    logic step;
    logic use_input;
    logic clear;
    logic last_sym;
    logic u;
    mem_t mem_q;
    mem_t mem_eff;
    sym_t sym;

    cfe_framer #(.DATA_BITS(DATA_BITS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .sof       (sof),
        .in_ready  (in_ready),
        .step      (step),
        .use_input (use_input),
        .clear     (clear),
        .last_sym  (last_sym)
    );

    assign u   = use_input & in_bit;
    assign sym = encode_sym(u, mem_eff);

    cfe_memory u_memory (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .clear   (clear),
        .u       (u),
        .mem_q   (mem_q),
        .mem_eff (mem_eff)
    );

    cfe_symout u_symout (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .sym       (sym),
        .last      (last_sym),
        .out_valid (out_valid),
        .out_v1    (out_v1),
        .out_v2    (out_v2),
        .out_eof   (out_eof)
    );

    // R1: an accepted bit yields a symbol on the next cycle.
    assert_sym_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R2: within a frame, V2 of a symbol is the bit (V1^V2) of the one before.
    assert_chain_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(out_eof) && !$past(clear))
        |-> (out_v2 == ($past(out_v1) ^ $past(out_v2))));

    // R5: ready drops only right after the final data bit of a frame was taken.
    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> (out_valid && !out_eof));

    // R7: the trellis is back in state 00 when the end marker is shown.
    assert_clean_end_R7: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (mem_q == '0));

endmodule

// File: tb/sim_conv_flush_encoder.sv
module sim_conv_flush_encoder;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, out_valid, out_v1, out_v2, out_eof;

    int checks = 0;
    int errors = 0;

    // Reference model state, built from the requirements.
    int   m_cnt = 0;
    int   m_fl  = 0;
    logic m_m1  = 1'b0;
    logic g_v1, g_v2, g_eof;

    always #2 clk = ~clk;

    conv_flush_encoder #(.DATA_BITS(N)) u0 (
        .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_valid(out_valid), .out_v1(out_v1),
        .out_v2(out_v2), .out_eof(out_eof)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Called at a falling edge: drives one cycle, checks the result at the next.
    task automatic step(input logic v, input logic b, input logic s);
        logic rdy, ev, e1, e2, eo;
        string tg;
        rdy = (m_fl == 0);
        in_valid = v; in_bit = b; sof = s;
        ev = 1'b0; e1 = 1'b0; e2 = 1'b0; eo = 1'b0; tg = "R2";
        chk("R5 in_ready", int'(in_ready), int'(rdy));
        if (rdy) begin
            if (s) begin m_m1 = 1'b0; m_cnt = 0; end
            if (v) begin
                ev = 1'b1; e1 = b ^ m_m1; e2 = m_m1; m_m1 = b;
                m_cnt++;
                if (m_cnt == N) begin m_cnt = 0; m_fl = 2; end
            end
        end else begin
            tg = "R4"; ev = 1'b1; e1 = m_m1; e2 = m_m1; m_m1 = 1'b0;
            m_fl--;
            eo = (m_fl == 0);
        end
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), int'(ev));
        if (ev) begin
            chk({tg, " v1"}, int'(out_v1), int'(e1));
            chk({tg, " v2"}, int'(out_v2), int'(e2));
        end
        chk("R6 out_eof", int'(out_eof), int'(eo));
        g_v1 = out_v1; g_v2 = out_v2; g_eof = out_eof;
        in_valid = 1'b0; sof = 1'b0; in_bit = 1'b0;
    endtask

    task automatic idle2();
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", int'(out_valid), 0);
        chk("R11 reset in_ready", int'(in_ready), 1);
        rst = 1'b0;
        chk("R11 out_eof", int'(out_eof), 0);
        @(negedge clk);
        chk("R11 released out_valid", int'(out_valid), 0);
        chk("R11 released in_ready", int'(in_ready), 1);

        // R3 reference sequence
        step(1'b1, 1'b1, 1'b1); chk("R3 s0", {g_v1, g_v2}, 2'b10);
        step(1'b1, 1'b1, 1'b0); chk("R3 s1", {g_v1, g_v2}, 2'b01);
        step(1'b1, 1'b0, 1'b0); chk("R3 s2", {g_v1, g_v2}, 2'b11);
        step(1'b1, 1'b1, 1'b0); chk("R3 s3", {g_v1, g_v2}, 2'b10);
        step(1'b0, 1'b0, 1'b0); chk("R3 s4", {g_v1, g_v2}, 2'b11);
        step(1'b0, 1'b0, 1'b0); chk("R3 s5", {g_v1, g_v2, g_eof}, 3'b001);

        // R7: trellis back at 00, next frame's first bit 1 gives 10
        step(1'b1, 1'b1, 1'b0); chk("R7 first after eof", {g_v1, g_v2}, 2'b10);
        for (int i = 0; i < N - 1; i++) step(1'b1, 1'b1, 1'b0);
        idle2();
        chk("R7 frame end", int'(g_eof), 1);

        // Exhaustive sweep with gaps; junk bits and sof during the tail (R5, R9, R10)
        for (int p = 0; p < (1 << N); p++) begin
            for (int i = 0; i < N; i++) begin
                if (((p + i) % 3) == 0) step(1'b0, 1'b1, 1'b0);
                step(1'b1, p[i], (i == 0) && p[0]);
            end
            step(1'b1, p[1], 1'b1);
            step(1'b1, p[2], 1'b1);
            chk("R9 eof despite sof in tail", int'(g_eof), 1);
        end

        // R8: abandon a frame with sof
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1); chk("R8 cleared m1", {g_v1, g_v2}, 2'b10);
        for (int i = 0; i < N - 1; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R8 no early eof", int'(g_eof), 0);
        step(1'b0, 1'b0, 1'b0);
        chk("R8 eof after N bits from sof", int'(g_eof), 1);

        // R10: idle cycles keep the state
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0); chk("R10 no symbol", int'(out_valid), 0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0); chk("R10 m1 held", {g_v1, g_v2}, 2'b01);
        for (int i = 0; i < N - 2; i++) step(1'b1, 1'b0, 1'b0);
        idle2();
        chk("R10 frame end", int'(g_eof), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule